// File: doc/BRIEF.md
# Register Access Sequencer with Trailing Interface-Flush Write

This block sits between a simple register-access request port and the command side of an I2C master. A request names a 7-bit device address, a one-byte register address, a direction flag and one data byte. The sequencer passes that transfer to the master as one command. When the master reports completion without an acknowledge error, the sequencer sends a second command on its own. This command is a one-byte write of 0xFF to register 0xFF on the same device. Its purpose is to drive the slave's bus interface back into a known state after every access.

The outcome goes back to the requester as a single-cycle response. The response carries the read data, an error flag for a failed primary transfer and a warning flag for a failed flush write. A failed flush write never turns a good access into an error. The read data from the primary transfer is still returned. A failed primary transfer skips the flush write and responds at once. The sequencer never retries anything itself. The bit-level I2C engine is outside the block and is reached through a command/done handshake.

Top module: `racc_seq`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, req_ready is 1, cmd_valid is 0 and rsp_valid is 0.
- R2: A request is accepted in a cycle with req_valid=1 and req_ready=1. req_ready then stays 0 until the cycle after the response pulse, so only one request is in flight.
- R3: The cycle after acceptance, cmd_valid rises with cmd_dev, cmd_reg, cmd_write (1 = write) and cmd_wdata equal to the request fields. These outputs hold stable until a cycle with cmd_ready=1.
- R4: For a successful read, rsp_rdata equals the cmd_rdata presented with the primary cmd_done. For a write, rsp_rdata is 0x00.
- R5: One cycle after a primary cmd_done with cmd_nack=0, exactly one flush command is presented: cmd_dev equal to the request device, cmd_reg=0xFF, cmd_wdata=0xFF, cmd_write=1.
- R6: When the flush command ends with cmd_nack=1, the response has rsp_warn=1 and rsp_error=0, and rsp_rdata keeps the value from R4. When the flush command ends with cmd_nack=0, rsp_warn is 0.
- R7: When the primary cmd_done carries cmd_nack=1, rsp_valid pulses in the next cycle with rsp_error=1, rsp_warn=0 and rsp_rdata=0x00, and no flush command is issued.
- R8: Each request causes exactly one command handshake (cmd_valid and cmd_ready both 1) if the primary transfer fails, and exactly two if it succeeds. Nothing is retried.
- R9: rsp_valid is a one-cycle pulse. It comes one cycle after the cmd_done that ends the sequence.
- R10: A cmd_done pulse received while no command is awaiting completion (idle, or a command presented but not yet taken) has no effect on the sequence or on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_dev | input | 7 | Target device address |
| req_reg | input | 8 | Target register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Read data (0 for writes and failures) |
| rsp_error | output | 1 | Primary transfer failed |
| rsp_warn | output | 1 | Flush write failed |
| cmd_valid | output | 1 | Command presented to the I2C master |
| cmd_ready | input | 1 | Master takes the command |
| cmd_dev | output | 7 | Command device address |
| cmd_reg | output | 8 | Command register address |
| cmd_write | output | 1 | Command direction, 1 = write |
| cmd_wdata | output | 8 | Command write data |
| cmd_done | input | 1 | Master completion pulse |
| cmd_nack | input | 1 | Completion carried an acknowledge error |
| cmd_rdata | input | 8 | Data read by the completed command |

## Verification
A wrong state register shows up quickly at the command port. A missing flush, an extra flush or a flush after a failure changes the handshake count and the command fields within one cycle of the primary completion. A wrong outcome latch shows up only at the response pulse, as a swapped error or warning flag or as stale read data. The sweep therefore covers every combination of direction, primary and flush outcome, and command-accept and completion latency. It also places stray completion pulses where the sequencer must ignore them.

// File: rtl/racc_pkg.sv
// Shared types for the register-access sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package racc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PRIMARY   = 3'd1,
        ST_WAIT_PRI  = 3'd2,
        ST_FLUSH     = 3'd3,
        ST_WAIT_FL   = 3'd4,
        ST_RESPOND   = 3'd5
    } racc_state_e;
endpackage

// File: rtl/racc_fsm.sv
// Sequencing state machine: primary command, optional flush command, response.
// Assumes cmd_done is meaningful only while a taken command is outstanding.
module racc_fsm
    import racc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_fire,
    input  logic        cmd_ready,
    input  logic        cmd_done,
    input  logic        cmd_nack,
    output racc_state_e state
);
    racc_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_fire)  state_nx = ST_PRIMARY;
            ST_PRIMARY:  if (cmd_ready) state_nx = ST_WAIT_PRI;
            ST_WAIT_PRI: if (cmd_done)  state_nx = cmd_nack ? ST_RESPOND : ST_FLUSH;
            ST_FLUSH:    if (cmd_ready) state_nx = ST_WAIT_FL;
            ST_WAIT_FL:  if (cmd_done)  state_nx = ST_RESPOND;
            ST_RESPOND:                 state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R7: a failed primary completion must never lead to the flush state.
    p_fail_no_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PRI && cmd_done && cmd_nack) |=> (state == ST_RESPOND));
    // R9: the respond state lasts exactly one cycle.
    p_respond_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESPOND) |=> (state == ST_IDLE));
endmodule

// File: rtl/racc_cmd_sel.sv
// Captures the accepted request and drives the command port, choosing
// between the request fields and the fixed flush write.
// Assumes req_fire is asserted only in the idle state.
module racc_cmd_sel
    import racc_pkg::*;
#(
    parameter int DEV_W  = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] FLUSH_REG  = '1,
    parameter logic [DATA_W-1:0] FLUSH_DATA = '1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  racc_state_e       state,
    input  logic              req_fire,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cmd_ready,
    output logic              held_write,
    output logic              cmd_valid,
    output logic [DEV_W-1:0]  cmd_dev,
    output logic [ADDR_W-1:0] cmd_reg,
    output logic              cmd_write,
    output logic [DATA_W-1:0] cmd_wdata
);
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] wdata_q;
    logic              flush_sel;

    // Hold the request fields for the duration of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q      <= '0;
            reg_q      <= '0;
            wdata_q    <= '0;
            held_write <= 1'b0;
        end else if (req_fire) begin
            dev_q      <= req_dev;
            reg_q      <= req_reg;
            wdata_q    <= req_wdata;
            held_write <= req_write;
        end
    end

    // Command fields: the request itself, or the fixed flush write.
    always_comb begin
        flush_sel = (state == ST_FLUSH);
        cmd_valid = (state == ST_PRIMARY) || flush_sel;
        cmd_dev   = dev_q;
        cmd_reg   = flush_sel ? FLUSH_REG  : reg_q;
        cmd_wdata = flush_sel ? FLUSH_DATA : wdata_q;
        cmd_write = flush_sel ? 1'b1       : held_write;
    end

    // R3: a presented command holds its fields until it is taken.
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_dev) &&
            $stable(cmd_reg) && $stable(cmd_wdata) && $stable(cmd_write)));
    // R5: the device address does not change between primary and flush.
    p_same_dev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_PRI) |=> $stable(cmd_dev));
endmodule

// File: rtl/racc_result.sv
// Collects the outcome of the sequence: read data, error and warning.
// Assumes cmd_done is a single-cycle pulse from the I2C master.
module racc_result
    import racc_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  racc_state_e       state,
    input  logic              req_fire,
    input  logic              held_write,
    input  logic              cmd_done,
    input  logic              cmd_nack,
    input  logic [DATA_W-1:0] cmd_rdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              rsp_warn
);
    // Clear on accept, record primary then flush outcomes.
    always_ff @(posedge clk) begin
        if (!rst_n || req_fire) begin
            rsp_rdata <= '0;
            rsp_error <= 1'b0;
            rsp_warn  <= 1'b0;
        end else if (cmd_done && state == ST_WAIT_PRI) begin
            rsp_error <= cmd_nack;
            if (!cmd_nack && !held_write) rsp_rdata <= cmd_rdata;
        end else if (cmd_done && state == ST_WAIT_FL) begin
            rsp_warn <= cmd_nack;
        end
    end

    // R6: a flush failure never disturbs already captured read data.
    p_warn_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_FL) |=> $stable(rsp_rdata) && !rsp_error);
    // R7: error and warning are never reported together.
    p_err_excl_warn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESPOND) |-> !(rsp_error && rsp_warn));
endmodule

// File: rtl/racc_seq.sv
// Register-access sequencer top: accepts one request, issues it to the I2C
// master, follows a successful transfer with a flush write of FLUSH_DATA to
// FLUSH_REG on the same device, then pulses a response.
// Assumes the master raises cmd_done once per taken command.
module racc_seq
    import racc_pkg::*;
#(
    parameter int DEV_W  = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] FLUSH_REG  = '1,
    parameter logic [DATA_W-1:0] FLUSH_DATA = '1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              rsp_warn,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DEV_W-1:0]  cmd_dev,
    output logic [ADDR_W-1:0] cmd_reg,
    output logic              cmd_write,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_done,
    input  logic              cmd_nack,
    input  logic [DATA_W-1:0] cmd_rdata
);
    racc_state_e state;
    logic        req_fire;
    logic        held_write;

    // Handshake decode at the request edge.
    always_comb begin
        req_ready = (state == ST_IDLE);
        req_fire  = req_valid && req_ready;
        rsp_valid = (state == ST_RESPOND);
    end

    racc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .cmd_nack(cmd_nack), .state(state)
    );

    racc_cmd_sel #(
        .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FLUSH_REG(FLUSH_REG), .FLUSH_DATA(FLUSH_DATA)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n), .state(state), .req_fire(req_fire),
        .req_dev(req_dev), .req_reg(req_reg), .req_write(req_write),
        .req_wdata(req_wdata), .cmd_ready(cmd_ready), .held_write(held_write),
        .cmd_valid(cmd_valid), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata)
    );

    racc_result #(.DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .state(state), .req_fire(req_fire),
        .held_write(held_write), .cmd_done(cmd_done), .cmd_nack(cmd_nack),
        .cmd_rdata(cmd_rdata), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .rsp_warn(rsp_warn)
    );

    // R2: accepting a request drops ready in the next cycle.
    p_one_in_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire |=> !req_ready);
    // R9: the response is a single-cycle pulse.
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R10: completion in idle does not start a response.
    p_idle_done_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid && cmd_done) |=> (req_ready && !rsp_valid));
endmodule

// File: tb/sim_racc_seq.sv
`timescale 1ns/100ps
// Near-exhaustive sweep of the sequencer with a bench-side command responder.
module sim_racc_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_write, req_ready;
    logic [6:0] req_dev;
    logic [7:0] req_reg, req_wdata;
    logic       rsp_valid, rsp_error, rsp_warn;
    logic [7:0] rsp_rdata;
    logic       cmd_valid, cmd_ready, cmd_write, cmd_done, cmd_nack;
    logic [6:0] cmd_dev;
    logic [7:0] cmd_reg, cmd_wdata, cmd_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int hs_cnt   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    racc_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_reg(req_reg), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_error(rsp_error), .rsp_warn(rsp_warn), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
        .cmd_nack(cmd_nack), .cmd_rdata(cmd_rdata)
    );

    // Count command handshakes seen at the port.
    always @(posedge clk) if (rst_n && cmd_valid && cmd_ready) hs_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Let the master take a presented command after rdy stall cycles.
    task automatic take_cmd(input int rdy, input bit stray);
        for (int k = 0; k < rdy; k++) begin
            if (stray && k == 0) begin cmd_done = 1'b1; cmd_nack = 1'b1; end
            @(negedge clk);
            cmd_done = 1'b0; cmd_nack = 1'b0;
            chk(cmd_valid == 1'b1, "R3 hold", cmd_valid, 1);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic finish_cmd(input int lat, input bit nack, input logic [7:0] rd);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            chk(!cmd_valid && !rsp_valid, "R8 quiet", cmd_valid, 0);
        end
        cmd_done = 1'b1; cmd_nack = nack; cmd_rdata = rd;
        @(negedge clk);
        cmd_done = 1'b0; cmd_nack = 1'b0; cmd_rdata = 8'h00;
    endtask

    task automatic access(input logic [6:0] dev, input logic [7:0] ra, input bit wr,
                          input logic [7:0] wd, input bit pnack, input bit fnack,
                          input int rdy, input int lat, input logic [7:0] rd);
        int hs0;
        logic [7:0] exp_rd;
        exp_rd = (!pnack && !wr) ? rd : 8'h00;
        chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);
        req_valid = 1'b1; req_dev = dev; req_reg = ra; req_write = wr; req_wdata = wd;
        hs0 = hs_cnt;
        @(negedge clk);
        req_valid = 1'b0; req_reg = 8'h00; req_wdata = 8'h00; req_dev = 7'h00;
        chk(!req_ready, "R2 busy", req_ready, 0);
        chk(cmd_valid && cmd_dev == dev && cmd_reg == ra && cmd_write == wr &&
            (!wr || cmd_wdata == wd), "R3 fields", {cmd_dev, cmd_reg}, {dev, ra});
        take_cmd(rdy, 1'b1);
        finish_cmd(lat, pnack, rd);
        if (!pnack) begin
            chk(cmd_valid && cmd_dev == dev && cmd_reg == 8'hFF &&
                cmd_wdata == 8'hFF && cmd_write, "R5 flush cmd",
                {cmd_dev, cmd_reg, cmd_wdata}, {dev, 16'hFFFF});
            chk(!rsp_valid, "R9 no early rsp", rsp_valid, 0);
            take_cmd(rdy, 1'b0);
            finish_cmd(lat, fnack, 8'h3C);
        end
        chk(rsp_valid == 1'b1, "R9 rsp timing", rsp_valid, 1);
        chk(rsp_error == pnack, "R7 error", rsp_error, pnack);
        chk(rsp_warn == (!pnack && fnack), "R6 warn", rsp_warn, !pnack && fnack);
        chk(rsp_rdata == exp_rd, "R4 rdata", rsp_rdata, exp_rd);
        chk(!cmd_valid, "R7 no flush after fail", cmd_valid, 0);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 pulse width", rsp_valid, 0);
        chk(hs_cnt - hs0 == (pnack ? 1 : 2), "R8 handshakes", hs_cnt - hs0, pnack ? 1 : 2);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_dev = '0; req_reg = '0; req_write = 1'b0;
        req_wdata = '0; cmd_ready = 1'b0; cmd_done = 1'b0; cmd_nack = 1'b0; cmd_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready && !cmd_valid && !rsp_valid, "R1 reset", {req_ready, cmd_valid, rsp_valid}, 3'b100);
        for (int d = 0; d < 3; d++) begin
            for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
            for (int f = 0; f < 2; f++)
            for (int r = 0; r < 3; r++)
            for (int l = 0; l < 3; l++) begin
                logic [6:0] dev;
                logic [7:0] ra, wd, rd;
                dev = (d == 0) ? 7'h00 : (d == 1) ? 7'h48 : 7'h7F;
                ra  = 8'((d * 37 + w * 11 + r * 5 + l) ^ 8'hA5);
                wd  = 8'(p * 64 + f * 32 + r * 7 + l * 3 + d);
                rd  = 8'((dev * 7 + ra * 13) ^ 8'h5A);
                // R10: stray completion while idle is ignored.
                cmd_done = 1'b1; cmd_nack = 1'b1; cmd_rdata = 8'hEE;
                @(negedge clk);
                cmd_done = 1'b0; cmd_nack = 1'b0; cmd_rdata = 8'h00;
                chk(!rsp_valid && req_ready && !cmd_valid, "R10 idle done", rsp_valid, 0);
                access(dev, ra, w[0], wd, p[0], f[0], r, l, rd);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule